// File: doc/BRIEF.md
# PHY management register file

This block models the management register space of an Ethernet PHY. It holds thirty-two 16-bit registers behind a plain access port with three parts: a register number, a write strobe with write data, and a read data output. Most registers are ordinary storage with fixed reset values. The basic status register, the link-partner ability register and the speed/duplex diagnostic register are not read from storage. Their values are built at read time from the advertisement register and a link-status input.

As a result, the modelled PHY always agrees with the local side. The link partner appears to offer exactly the modes that the local side advertises. The diagnostic register reports the best speed and duplex among those modes. Negotiation therefore always succeeds in the best advertised mode, provided the link input is high.

A management engine or bus bridge drives the port directly. Read data is combinational from the register number. Writes take effect at the clock edge that samples the strobe.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Only the low 5 bits of the register number select a register. Higher bits of the number are ignored, so number 0x24 reaches register 4.
- R2: A write stores bits 15:0 of the write data into the selected register at the clock edge that samples the strobe. Bits above 15 are discarded.
- R3: After reset, the registers hold these values: register 0 = 0x3100, register 2 = 0x0300, register 3 = 0xE400, register 4 = 0x01E1. Every other stored register reads 0.
- R4: With link_up high, register 1 reads 0x782C. This sets bits 14..11 (abilities), bit 5 (negotiation done), bit 3 (negotiation capable) and bit 2 (link).
- R5: With link_up low, register 1 reads 0x0000.
- R6: Register 5 reads 0x4000, OR register 4 bits 8:5 in the same positions, OR 0x0001. This holds whatever the link state.
- R7: With link_up high, register 18 reads as follows: bit 10 = reg4[7] | reg4[8] (100 Mb/s), bit 11 = reg4[8] | reg4[6] (full duplex), and all other bits 0.
- R8: With link_up low, register 18 reads 0x0000.
- R9: Read data follows the register number and the current contents in the same cycle. A read of a register that is being written in that cycle returns the old value.
- R10: A write to register 1, 5 or 18 has no effect on the value read back from that register. Such reads stay computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link status feeding the computed registers |
| req_num | input | 8 | Register number; only bits 4:0 are decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; only bits 15:0 are stored |
| rd_data | output | 16 | Read data for the selected register |

## Verification
A read has zero cycles of latency. The bench therefore drives the register number and link_up just after a falling edge and compares rd_data a nanosecond later, within the same low phase. A write lands at the next rising edge. The bench checks the old value while the strobe is still high, before that edge (R9). It checks the new value after the following falling edge. Derived registers are rechecked after each change to register 4 or to link_up. Each of these checks falls in the same half-period as its stimulus.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32,
  parameter int REQ_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [REQ_W-1:0]  req_num,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SEL_W = $clog2(NUM_REGS);
  localparam logic [SEL_W-1:0] R_CTRL = SEL_W'(0);
  localparam logic [SEL_W-1:0] R_STAT = SEL_W'(1);
  localparam logic [SEL_W-1:0] R_ID1  = SEL_W'(2);
  localparam logic [SEL_W-1:0] R_ID2  = SEL_W'(3);
  localparam logic [SEL_W-1:0] R_ADV  = SEL_W'(4);
  localparam logic [SEL_W-1:0] R_LPA  = SEL_W'(5);
  localparam logic [SEL_W-1:0] R_DIAG = SEL_W'(18);
  localparam logic [DATA_W-1:0] STAT_UP = DATA_W'(16'h782C);

  logic [DATA_W-1:0] store [NUM_REGS];
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] adv;
  logic              spd100, fdx;
  logic              unused_bits;

  assign sel    = req_num[SEL_W-1:0];
  assign adv    = store[R_ADV];
  assign spd100 = adv[7] | adv[8];
  assign fdx    = adv[8] | adv[6];
  assign unused_bits = ^{req_num[REQ_W-1:SEL_W], wr_data[BUS_W-1:DATA_W]};

  function automatic logic [DATA_W-1:0] init_val(int idx);
    case (idx)
      0:       return DATA_W'(16'h3100);
      2:       return DATA_W'(16'h0300);
      3:       return DATA_W'(16'hE400);
      4:       return DATA_W'(16'h01E1);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) store[i] <= init_val(i);
    end else if (wr_en) begin
      store[sel] <= wr_data[DATA_W-1:0];
    end
  end

  always_comb begin
    rd_data = store[sel];
    case (sel)
      R_STAT: rd_data = link_up ? STAT_UP : '0;
      R_LPA: begin
        rd_data = '0;
        rd_data[14]  = 1'b1;
        rd_data[8:5] = adv[8:5];
        rd_data[0]   = 1'b1;
      end
      R_DIAG: begin
        rd_data = '0;
        rd_data[10] = link_up & spd100;
        rd_data[11] = link_up & fdx;
      end
      default: ;
    endcase
  end

  // R2
  adv_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == R_ADV) |=> (adv == $past(wr_data[DATA_W-1:0])));

  // R4
  stat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == R_STAT && link_up) |-> (rd_data[14:11] == 4'hF && rd_data[5] && rd_data[2]));

  // R5
  stat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == R_STAT && !link_up) |-> (rd_data == '0));

  // R6
  lpa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == R_LPA) |-> (rd_data[14] && rd_data[0] && rd_data[8:5] == store[R_ADV][8:5]));

  // R7
  diag_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == R_DIAG) |-> (rd_data[9:0] == '0 && rd_data[DATA_W-1:12] == '0));

  // R8
  diag_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == R_DIAG && !link_up) |-> (rd_data == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (adv == $past(adv)));

  wire unused_ids = ^{R_CTRL, R_ID1, R_ID2};

endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic [7:0]  req_num = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  phy_mgmt_regs i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_num(req_num),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(string tag, logic [7:0] num, logic [15:0] exp);
    @(negedge clk);
    req_num = num;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic wr(logic [7:0] num, logic [31:0] val);
    @(negedge clk);
    req_num = num; wr_data = val; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rd("R3 reg0", 8'd0, 16'h3100);
    rd("R3 reg2", 8'd2, 16'h0300);
    rd("R3 reg3", 8'd3, 16'hE400);
    rd("R3 reg4", 8'd4, 16'h01E1);
    rd("R3 reg7", 8'd7, 16'h0000);
    rd("R3 reg31", 8'd31, 16'h0000);
  endtask

  task automatic t_status;
    link_up = 1'b1;
    rd("R4 status up", 8'd1, 16'h782C);
    link_up = 1'b0;
    rd("R5 status down", 8'd1, 16'h0000);
    link_up = 1'b1;
  endtask

  task automatic t_derived;
    rd("R6 lpa reset", 8'd5, 16'h41E1);
    rd("R7 diag reset", 8'd18, 16'h0C00);
    wr(8'd4, 32'h0000_0040);
    rd("R6 lpa 10fd", 8'd5, 16'h4041);
    rd("R7 diag 10fd", 8'd18, 16'h0800);
    wr(8'd4, 32'h0000_0080);
    rd("R7 diag 100hd", 8'd18, 16'h0400);
    wr(8'd4, 32'h0000_0020);
    rd("R7 diag 10hd", 8'd18, 16'h0000);
    rd("R6 lpa 10hd", 8'd5, 16'h4021);
    wr(8'd4, 32'h0000_FFFF);
    rd("R6 lpa all", 8'd5, 16'h41E1);
    link_up = 1'b0;
    rd("R8 diag down", 8'd18, 16'h0000);
    rd("R6 lpa link down", 8'd5, 16'h41E1);
    link_up = 1'b1;
    rd("R7 diag all", 8'd18, 16'h0C00);
  endtask

  task automatic t_write;
    wr(8'd9, 32'hDEAD_BEEF);
    rd("R2 upper dropped", 8'd9, 16'hBEEF);
    wr(8'hE7, 32'h0000_1234);
    rd("R1 alias write", 8'd7, 16'h1234);
    rd("R1 alias read", 8'h24, 16'hFFFF);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_num = 8'd4; wr_data = 32'h0000_0140; wr_en = 1'b1;
    #1 check("R9 old value during write", rd_data, 16'hFFFF);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 new value after edge", rd_data, 16'h0140);
  endtask

  task automatic t_ignored;
    wr(8'd1, 32'h0000_0000);
    rd("R10 status after write", 8'd1, 16'h782C);
    wr(8'd5, 32'h0000_0000);
    rd("R10 lpa after write", 8'd5, 16'h4141);
    wr(8'd18, 32'h0000_FFFF);
    rd("R10 diag after write", 8'd18, 16'h0C00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status();
    t_derived();
    t_write();
    t_same_cycle();
    t_ignored();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule